// File: doc/BRIEF.md
# Prioritizing Two-Line Interrupt Controller

This block gathers level-sensitive interrupt requests from a parameterised set of peripheral sources and steers each one to one of two active-low processor interrupt lines: a normal line (`nIrq`) and a fast line (`nFiq`). Every source has its own enable bit, routing bit and priority value. A small synchronous register port holds these settings. Software reads status through the same port. The raw view shows every sampled request whatever its enable. Two masked views show only the pending requests that reach the normal line and the fast line.

For each line the block also reports the number of the winning source. The winner is the pending source with the smallest priority value. The controller does not nest and keeps no in-service level, so the winner follows the pending set directly. A single write to the control address returns every source's settings to their defaults.

Register map (8-bit address, 32-bit data):
- `addr[7:6]=00`: per-source setting word, with the source number in `addr[5:0]`. Bit 0 is the enable. Bit 1 is the route (0 = normal line, 1 = fast line). Bits 7:2 hold the priority.
- `addr[7:6]=01`: status words, with the word number in `addr[3:0]`. Setting `addr[5:4]` to 0 gives the raw view, 1 the normal-line masked view and 2 the fast-line masked view.
- `0x80` and `0x81`: the winner registers for the normal line and the fast line.
- `0xC0`: the control address. A write with bit 0 set clears all settings.

Top module: `prio_intc`

## Requirements
- R1: After reset every source is disabled, routed to the normal line and at priority 0. Both `nIrq` and `nFiq` are high. Every setting word reads 0.
- R2: A write to setting address `n` stores the enable from bit 0, the route from bit 1 and the priority from bits 7:2. A read returns the stored value in the same layout. Read data appears on `regRdata` in the cycle after the cycle with `regRd` high.
- R3: Requests are sampled on every clock edge. Bit `n` of the raw status word shows the sampled request of source `n`, whatever its enable or route.
- R4: The normal-line masked word holds bits for sources that are requesting, enabled and have route 0. The fast-line masked word holds bits for sources that are requesting, enabled and have route 1. No source is ever set in both words.
- R5: `nIrq` is low exactly while the normal-line masked set is non-empty. `nFiq` is low exactly while the fast-line masked set is non-empty. Both follow a request change one clock edge later.
- R6: The winner register of a line holds the number of the pending source with the smallest priority value in bits 5:0, with bit 31 clear. Among equal priority values the lower source number wins.
- R7: When no source is pending on a line, its winner register reads with bit 31 set and all other bits 0.
- R8: A write to `0xC0` with bit 0 set clears every enable, route and priority. From the next cycle on, both lines are high and every setting word reads 0.
- R9: A requesting source that is disabled has no effect on either line or either winner register.
- R10: There is no acknowledge and no nesting. A newly pending source with a smaller priority value becomes the winner as soon as it is sampled. When it drops, the previous winner returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | NUM_SRC | Level request per source |
| regAddr | input | 8 | Register address |
| regWr | input | 1 | Write strobe |
| regRd | input | 1 | Read strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid one cycle after the read strobe |
| nIrq | output | 1 | Normal interrupt line, active low |
| nFiq | output | 1 | Fast interrupt line, active low |

## Verification
A corrupted enable, route or priority cell shows up one clock after the next request on that source. It appears as a wrong level on `nIrq` or `nFiq`, a wrong bit in a masked status word, or a wrong winner number. A setting that was not cleared by the clear command is visible in its setting word on the next read. A fault in the tie-break or in the priority comparison only appears when two pending sources share a line. For that reason the stimulus forces ties and mixes priorities on every random step.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    RS_CFG, RS_RAW, RS_IRQ, RS_FIQ, RS_ACT_IRQ, RS_ACT_FIQ, RS_NONE
  } readSel_e;

  typedef struct packed {
    logic     cfgWe;
    logic     initAll;
    logic     rdEn;
    readSel_e rsel;
    logic [5:0] idx;
  } strobe_t;
endpackage

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic              clrBit,
  output strobe_t           strobes
);
  always_comb begin
    strobes         = '0;
    strobes.rsel    = RS_NONE;
    strobes.rdEn    = regRd;
    strobes.idx     = regAddr[5:0];
    case (regAddr[7:6])
      2'b00: begin
        strobes.cfgWe = regWr;
        strobes.rsel  = RS_CFG;
      end
      2'b01: begin
        case (regAddr[5:4])
          2'd0:    strobes.rsel = RS_RAW;
          2'd1:    strobes.rsel = RS_IRQ;
          2'd2:    strobes.rsel = RS_FIQ;
          default: strobes.rsel = RS_NONE;
        endcase
      end
      2'b10: strobes.rsel = regAddr[0] ? RS_ACT_FIQ : RS_ACT_IRQ;
      default: strobes.initAll = regWr & clrBit;
    endcase
  end
endmodule

// File: rtl/prio_intc_arb.sv
module prio_intc_arb #(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 6,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]             masked,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
  output logic                           winValid,
  output logic [SRC_W-1:0]               winIdx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    best     = '1;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (masked[i] && (prio[i] <= best)) begin
        winValid = 1'b1;
        winIdx   = SRC_W'(i);
        best     = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 6,
  localparam int SRC_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
  localparam int WORDS  = (NUM_SRC + DATA_W - 1) / DATA_W,
  localparam int CFG_W  = 2 + PRIO_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  strobe_t            strobes,
  input  logic [CFG_W-1:0]   cfgWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               nIrq,
  output logic               nFiq
);
  logic [NUM_SRC-1:0]             reqQ, enVec, rtVec;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
  logic [1:0][NUM_SRC-1:0]        lineMasked;
  logic [1:0]                     lineValid;
  logic [1:0][SRC_W-1:0]          lineIdx;
  logic                           idxOk;

  assign idxOk = (int'(strobes.idx) < NUM_SRC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqQ  <= '0;
      enVec <= '0;
      rtVec <= '0;
      prio  <= '0;
    end else begin
      reqQ <= irqReq;
      if (strobes.initAll) begin
        enVec <= '0;
        rtVec <= '0;
        prio  <= '0;
      end else if (strobes.cfgWe && idxOk) begin
        enVec[strobes.idx[SRC_W-1:0]] <= cfgWdata[0];
        rtVec[strobes.idx[SRC_W-1:0]] <= cfgWdata[1];
        prio[strobes.idx[SRC_W-1:0]]  <= cfgWdata[2 +: PRIO_W];
      end
    end
  end

  assign lineMasked[0] = reqQ & enVec & ~rtVec;
  assign lineMasked[1] = reqQ & enVec & rtVec;
  assign nIrq = ~|lineMasked[0];
  assign nFiq = ~|lineMasked[1];

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : gLine
      prio_intc_arb #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uArb (
        .masked  (lineMasked[g]),
        .prio    (prio),
        .winValid(lineValid[g]),
        .winIdx  (lineIdx[g])
      );

      assert_winner_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
        lineValid[g] |-> lineMasked[g][lineIdx[g]]);

      always_ff @(posedge clk) begin
        if (rstN && lineValid[g]) begin
          for (int i = 0; i < NUM_SRC; i++) begin
            if (lineMasked[g][i]) begin
              assert_winner_best_R6: assert ((prio[i] > prio[lineIdx[g]]) ||
                ((prio[i] == prio[lineIdx[g]]) && (i >= int'(lineIdx[g]))));
            end
          end
        end
      end
    end
  endgenerate

  // Status words, zero-padded to whole data words
  logic [WORDS*DATA_W-1:0] rawPad, irqPad, fiqPad;
  logic [3:0]              wIdx;
  logic [DATA_W-1:0]       rdNext, cfgWord, actWord;
  logic                    actSel;

  always_comb begin
    rawPad = '0; irqPad = '0; fiqPad = '0;
    rawPad[NUM_SRC-1:0] = reqQ;
    irqPad[NUM_SRC-1:0] = lineMasked[0];
    fiqPad[NUM_SRC-1:0] = lineMasked[1];
  end

  assign wIdx   = strobes.idx[3:0];
  assign actSel = (strobes.rsel == RS_ACT_FIQ);

  always_comb begin
    cfgWord = '0;
    if (idxOk) begin
      cfgWord[0]            = enVec[strobes.idx[SRC_W-1:0]];
      cfgWord[1]            = rtVec[strobes.idx[SRC_W-1:0]];
      cfgWord[2 +: PRIO_W]  = prio[strobes.idx[SRC_W-1:0]];
    end
    actWord = '0;
    if (lineValid[actSel]) actWord[SRC_W-1:0] = lineIdx[actSel];
    else                   actWord[DATA_W-1]  = 1'b1;
  end

  always_comb begin
    rdNext = '0;
    case (strobes.rsel)
      RS_CFG:     rdNext = cfgWord;
      RS_RAW:     if (int'(wIdx) < WORDS) rdNext = rawPad[int'(wIdx)*DATA_W +: DATA_W];
      RS_IRQ:     if (int'(wIdx) < WORDS) rdNext = irqPad[int'(wIdx)*DATA_W +: DATA_W];
      RS_FIQ:     if (int'(wIdx) < WORDS) rdNext = fiqPad[int'(wIdx)*DATA_W +: DATA_W];
      RS_ACT_IRQ,
      RS_ACT_FIQ: rdNext = actWord;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)             regRdata <= '0;
    else if (strobes.rdEn) regRdata <= rdNext;
  end

  assert_route_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lineMasked[0] & lineMasked[1]) == '0);

  assert_init_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.initAll |=> ($countones(enVec) == 0 && nIrq && nFiq));

  assert_irq_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    !nIrq |-> lineValid[0]);

  assert_fiq_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    !nFiq |-> lineValid[1]);
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqReq,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               nIrq,
  output logic               nFiq
);
  localparam int CFG_W = 2 + PRIO_W;

  strobe_t strobes;
  logic    unusedWdataBits;

  assign unusedWdataBits = ^regWdata[DATA_W-1:CFG_W];

  prio_intc_ctrl uCtrl (
    .regAddr(regAddr),
    .regWr  (regWr),
    .regRd  (regRd),
    .clrBit (regWdata[0]),
    .strobes(strobes)
  );

  prio_intc_dp #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .irqReq  (irqReq),
    .strobes (strobes),
    .cfgWdata(regWdata[CFG_W-1:0]),
    .regRdata(regRdata),
    .nIrq    (nIrq),
    .nFiq    (nFiq)
  );
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  localparam int CLK_P = 10;
  localparam int N     = 32;

  logic        clk = 0;
  logic        rstN = 0;
  logic [N-1:0] irqReq = '0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 0, regRd = 0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        nIrq, nFiq;

  int nChk = 0, nBad = 0, cyc = 0;
  bit done = 0;

  logic mEn [N];
  logic mRt [N];
  int   mPr [N];

  prio_intc #(.NUM_SRC(N), .PRIO_W(6)) uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .regAddr(regAddr),
    .regWr(regWr), .regRd(regRd), .regWdata(regWdata),
    .regRdata(regRdata), .nIrq(nIrq), .nFiq(nFiq));

  always #(CLK_P/2) clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      nChk++; nBad++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      summary();
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    nChk++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] expMask(int line);
    logic [31:0] m = '0;
    for (int i = 0; i < N; i++)
      m[i] = irqReq[i] & mEn[i] & (mRt[i] == (line == 1));
    return m;
  endfunction

  function automatic logic [31:0] expAct(int line);
    logic [31:0] m = expMask(line);
    int best = 1000, win = -1;
    for (int i = 0; i < N; i++)
      if (m[i] && mPr[i] < best) begin best = mPr[i]; win = i; end
    return (win < 0) ? 32'h8000_0000 : 32'(win);
  endfunction

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWr = 1;
    @(negedge clk);
    regWr = 0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1;
    @(negedge clk);
    regRd = 0;
    d = regRdata;
  endtask

  task automatic cfgSet(int s, logic en, logic rt, int pr);
    wrReg(8'(s), {24'd0, 6'(pr), rt, en});
    mEn[s] = en; mRt[s] = rt; mPr[s] = pr;
  endtask

  task automatic setReq(logic [N-1:0] v);
    @(negedge clk);
    irqReq = v;
    @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    logic [31:0] d;
    chk({tag, " R5 nIrq"}, {31'd0, nIrq}, {31'd0, ~|expMask(0)});
    chk({tag, " R5 nFiq"}, {31'd0, nFiq}, {31'd0, ~|expMask(1)});
    rdReg(8'h40, d); chk({tag, " R3 raw"}, d, irqReq);
    rdReg(8'h50, d); chk({tag, " R4 irq mask"}, d, expMask(0));
    rdReg(8'h60, d); chk({tag, " R4 fiq mask"}, d, expMask(1));
    rdReg(8'h80, d); chk({tag, " R6 act irq"}, d, expAct(0));
    rdReg(8'h81, d); chk({tag, " R6 act fiq"}, d, expAct(1));
  endtask

  initial begin
    logic [31:0] d;
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < N; i++) begin mEn[i] = 0; mRt[i] = 0; mPr[i] = 0; end
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 nIrq", {31'd0, nIrq}, 32'd1);
    chk("R1 nFiq", {31'd0, nFiq}, 32'd1);
    rdReg(8'd5, d); chk("R1 cfg", d, 32'd0);
    // R7 empty winner
    rdReg(8'h80, d); chk("R7 act irq none", d, 32'h8000_0000);
    rdReg(8'h81, d); chk("R7 act fiq none", d, 32'h8000_0000);

    // R2 write/read layout
    cfgSet(3, 1, 0, 17);
    rdReg(8'd3, d); chk("R2 cfg readback", d, 32'h45);
    cfgSet(30, 1, 1, 63);
    rdReg(8'd30, d); chk("R2 cfg readback fiq", d, 32'hFF);

    // R9 disabled source ignored
    setReq(32'h0000_0080);
    chk("R9 nIrq", {31'd0, nIrq}, 32'd1);
    chk("R9 nFiq", {31'd0, nFiq}, 32'd1);
    rdReg(8'h80, d); chk("R9 act irq", d, 32'h8000_0000);
    // R3 raw regardless of enable
    rdReg(8'h40, d); chk("R3 raw disabled", d, 32'h0000_0080);
    setReq('1);
    checkAll("all-high");

    // R6 tie broken by lower number
    cfgSet(3, 0, 0, 0);
    cfgSet(10, 1, 0, 5);
    cfgSet(4, 1, 0, 5);
    setReq(32'h0000_0410);
    rdReg(8'h80, d); chk("R6 tie", d, 32'd4);
    cfgSet(20, 1, 0, 1);
    setReq(32'h0010_0410);
    rdReg(8'h80, d); chk("R6 lower value wins", d, 32'd20);

    // R10 immediate preemption without acknowledge
    cfgSet(2, 1, 0, 0);
    setReq(32'h0010_0414);
    rdReg(8'h80, d); chk("R10 new winner", d, 32'd2);
    setReq(32'h0010_0410);
    rdReg(8'h80, d); chk("R10 back to previous", d, 32'd20);

    // fast line routing
    cfgSet(9, 1, 1, 7);
    setReq(32'h4000_0200);
    checkAll("fiq-route");

    // random mix with forced ties
    for (int it = 0; it < 300; it++) begin
      for (int k = 0; k < 3; k++)
        cfgSet(int'($urandom % N), 1'($urandom), 1'($urandom), int'($urandom % 4));
      setReq($urandom & $urandom);
      checkAll($sformatf("rand%0d", it));
    end

    // R8 clear command
    setReq('1);
    wrReg(8'hC0, 32'd1);
    for (int i = 0; i < N; i++) begin mEn[i] = 0; mRt[i] = 0; mPr[i] = 0; end
    chk("R8 nIrq", {31'd0, nIrq}, 32'd1);
    chk("R8 nFiq", {31'd0, nFiq}, 32'd1);
    rdReg(8'd20, d); chk("R8 cfg cleared", d, 32'd0);
    rdReg(8'd30, d); chk("R8 cfg cleared fiq", d, 32'd0);
    checkAll("after-clear");

    done = 1;
    summary();
  end
endmodule